// File: doc/BRIEF.md
# Flash Block Erase and Program Sequencer

This block erases one block of a parallel NOR-style flash and then fills it word by word from a local buffer. It works as a bus master on a simple synchronous flash port. Writes take one cycle. Read data returns in the cycle after the read strobe. Two command dialects are supported. The first is a status-register dialect, which issues direct commands and polls a ready bit. The second is an unlock-cycle dialect, which puts a two-write key before every command and polls a toggling bit.

A single start pulse latches the block offset, the buffer length in bytes, the dialect, the bus width code, and two timeouts, one for erase and one for programming. Each timeout is counted in poll ticks. The block then erases the block and waits for completion. For each bus word it fetches the data from the buffer, issues the program command and the data write in adjacent cycles, and waits again. Completion errors are decoded in priority order. Every supported run ends with a read-array write at address 0. The result is reported as a one-cycle done pulse plus a 3-bit error code.

Top module: `flash_seq`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0 and there is no bus or buffer activity.
- R2: Status dialect (dialect_i = 0) erase is two writes at the aligned block offset: 0x20, then 0xD0.
- R3: Unlock dialect (dialect_i = 1) erase is six writes. The first three are 0xAA at offset+0x555, 0x55 at offset+0x2AA and 0x80 at offset+0x555. The last three are 0xAA at offset+0x555, 0x55 at offset+0x2AA and 0x30 at the block offset.
- R4: Programming steps byte index i from 0 by the bus width (wsel_i 0/1/2 = 1/2/4 bytes) while i < length. Each word is prefixed by a command: 0x40 at offset+i in the status dialect, or 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 in the unlock dialect. The data write at offset+i follows the last command write in the very next cycle. Its data is the buffer word at i masked to the width.
- R5: In the status dialect, each poll is one read at the aligned block offset. The operation is complete when bit 7 is set.
- R6: When the status dialect completes, errors are decoded in this priority: bit 1 gives code 1, bit 4 gives 2, bit 5 gives 3, and any of bits 2, 3, 6 gives 4. Otherwise the code is 0. Bit 0 and bits above 7 are ignored, and nothing is decoded while bit 7 is clear.
- R7: In the unlock dialect, each poll is two back-to-back reads at the aligned block offset. The operation is complete when bit 6 matches in both reads.
- R8: Each poll is preceded by a wait of CYC_PER_TICK cycles. At most 10 × timeout polls are made. If the operation is not complete by then the code is 5, and a timeout of 0 gives code 5 with no read.
- R9: A failed erase skips programming, and any failure stops the run. Every supported run ends with a write of 0xFF at address 0.
- R10: dialect_i of 2 or 3, or wsel_i of 3, gives code 6 with done_o in the next cycle and no bus activity.
- R11: done_o is a one-cycle pulse. err_o holds until the next accepted start. A start while busy_o is high is ignored.
- R12: Every bus address has its low bits cleared according to the width: none for width 1, bit 0 for width 2, bits 1:0 for width 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| blk_ofs_i | input | ADDR_W | Block byte offset |
| buf_len_i | input | LEN_W | Buffer length in bytes |
| dialect_i | input | 2 | 0 status, 1 unlock, others unsupported |
| wsel_i | input | 2 | Bus width code: 0/1/2 = 1/2/4 bytes, 3 unsupported |
| erase_to_i | input | TO_W | Erase timeout (×10 polls) |
| write_to_i | input | TO_W | Per-word program timeout (×10 polls) |
| buf_re_o | output | 1 | Buffer read strobe |
| buf_addr_o | output | LEN_W | Buffer byte index |
| buf_rdata_i | input | DW | Buffer word, valid the cycle after buf_re_o |
| bus_wr_o | output | 1 | Flash write strobe |
| bus_rd_o | output | 1 | Flash read strobe |
| bus_addr_o | output | ADDR_W | Flash byte address |
| bus_wdata_o | output | DW | Flash write data |
| bus_rdata_i | input | DW | Flash read data, valid the cycle after bus_rd_o |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 3 | Result code (0 ok, 1 protect, 2 program, 3 erase, 4 other, 5 timeout, 6 unsupported) |

## Verification
The bench builds the block with CYC_PER_TICK = 4, TO_W = 4, LEN_W = 8 and ADDR_W = 16. With short ticks, a full timeout window of 10 or 20 polls runs in a few hundred cycles, so timeout limits and exhaustion on both the erase and the program phase can be exercised directly. The small length field keeps the buffer model at 256 bytes. Unaligned offsets and odd lengths can then be combined with all three widths while every transaction is still compared in order.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam logic [7:0] C_SR_ERASE   = 8'h20;
  localparam logic [7:0] C_SR_CONFIRM = 8'hD0;
  localparam logic [7:0] C_SR_PROG    = 8'h40;
  localparam logic [7:0] C_READ_ARRAY = 8'hFF;
  localparam logic [7:0] C_UL_KEY1    = 8'hAA;
  localparam logic [7:0] C_UL_KEY2    = 8'h55;
  localparam logic [7:0] C_UL_ESETUP  = 8'h80;
  localparam logic [7:0] C_UL_BERASE  = 8'h30;
  localparam logic [7:0] C_UL_PROG    = 8'hA0;

  typedef enum logic [2:0] {
    E_NONE    = 3'd0,
    E_PROTECT = 3'd1,
    E_PROGRAM = 3'd2,
    E_ERASE   = 3'd3,
    E_OTHER   = 3'd4,
    E_TIMEOUT = 3'd5,
    E_NODEV   = 3'd6
  } err_e;

  // Prioritised decode of the status flags [6:1]; ready and reserved bits excluded.
  function automatic err_e decode_status(logic [6:1] fl);
    if (fl[1])                    return E_PROTECT;
    else if (fl[4])               return E_PROGRAM;
    else if (fl[5])               return E_ERASE;
    else if (fl[6] | fl[3] | fl[2]) return E_OTHER;
    else                          return E_NONE;
  endfunction

  // Index of the last write in a command group.
  function automatic logic [2:0] last_step(logic unl, logic prog);
    if (!unl)      return 3'd1;
    else if (prog) return 3'd3;
    else           return 3'd5;
  endfunction

endpackage

// File: rtl/fseq_tick_timer.sv
module fseq_tick_timer #(
  parameter int CYC_PER_TICK = 12500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_TICK - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/fseq_poll_eval.sv
module fseq_poll_eval
  import fseq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          unl_i,
  input  logic [DW-1:0] st_a_i,
  input  logic [DW-1:0] st_b_i,
  output logic          complete_o,
  output err_e          code_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^{st_a_i, st_b_i};

  always_comb begin
    if (unl_i) begin
      complete_o = (st_a_i[6] == st_b_i[6]);
      code_o     = E_NONE;
    end else begin
      complete_o = st_b_i[7];
      code_o     = st_b_i[7] ? decode_status(st_b_i[6:1]) : E_NONE;
    end
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int DW           = 32,
  parameter int LEN_W        = 12,
  parameter int TO_W         = 8,
  parameter int CYC_PER_TICK = 12500,
  parameter int UNLOCK_OFS   = 'h555,
  parameter int ACK_OFS      = 'h2AA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] blk_ofs_i,
  input  logic [LEN_W-1:0]  buf_len_i,
  input  logic [1:0]        dialect_i,
  input  logic [1:0]        wsel_i,
  input  logic [TO_W-1:0]   erase_to_i,
  input  logic [TO_W-1:0]   write_to_i,
  output logic              buf_re_o,
  output logic [LEN_W-1:0]  buf_addr_o,
  input  logic [DW-1:0]     buf_rdata_i,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic [DW-1:0]     bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        err_o
);
  localparam int RW = TO_W + 4;
  localparam logic [ADDR_W-1:0] UA = ADDR_W'(UNLOCK_OFS);
  localparam logic [ADDR_W-1:0] KA = ADDR_W'(ACK_OFS);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_PCHK, S_TICK, S_RD1, S_RD2, S_RD3, S_FETCH, S_FETCH_W, S_RA
  } state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DW-1:0]     data;
  } op_t;

  function automatic logic [ADDR_W-1:0] align(logic [ADDR_W-1:0] a, logic [1:0] ws);
    logic [ADDR_W-1:0] m;
    m = (ADDR_W'(1) << ws) - ADDR_W'(1);
    return a & ~m;
  endfunction

  function automatic logic [DW-1:0] lane_mask(logic [1:0] ws);
    logic [DW-1:0] m;
    m = '0;
    for (int b = 0; b < DW / 8; b++)
      if (b < (1 << ws)) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [RW-1:0] poll_limit(logic [TO_W-1:0] t);
    return (RW'(t) << 3) + (RW'(t) << 1);
  endfunction

  function automatic op_t op_for_step(logic unl, logic prog, logic [2:0] step,
                                      logic [ADDR_W-1:0] base, logic [ADDR_W-1:0] wa,
                                      logic [DW-1:0] wd);
    op_t o;
    o.addr = base;
    o.data = '0;
    if (!unl) begin
      o.addr = prog ? wa : base;
      if (step == 3'd0) o.data = DW'(prog ? C_SR_PROG : C_SR_ERASE);
      else              o.data = prog ? wd : DW'(C_SR_CONFIRM);
    end else if (!prog) begin
      case (step)
        3'd0:    begin o.addr = base + UA; o.data = DW'(C_UL_KEY1);   end
        3'd1:    begin o.addr = base + KA; o.data = DW'(C_UL_KEY2);   end
        3'd2:    begin o.addr = base + UA; o.data = DW'(C_UL_ESETUP); end
        3'd3:    begin o.addr = base + UA; o.data = DW'(C_UL_KEY1);   end
        3'd4:    begin o.addr = base + KA; o.data = DW'(C_UL_KEY2);   end
        default: begin o.addr = base;      o.data = DW'(C_UL_BERASE); end
      endcase
    end else begin
      case (step)
        3'd0:    begin o.addr = UA; o.data = DW'(C_UL_KEY1); end
        3'd1:    begin o.addr = KA; o.data = DW'(C_UL_KEY2); end
        3'd2:    begin o.addr = UA; o.data = DW'(C_UL_PROG); end
        default: begin o.addr = wa; o.data = wd;             end
      endcase
    end
    return o;
  endfunction

  state_e            st_q;
  logic [2:0]        step_q;
  logic              prog_q, unl_q, busy_q, done_q;
  logic [LEN_W:0]    idx_q;
  logic [LEN_W-1:0]  len_q;
  logic [DW-1:0]     dat_q, st0_q;
  logic [RW-1:0]     rem_q;
  logic [ADDR_W-1:0] ofs_q;
  logic [1:0]        wsel_q;
  logic [TO_W-1:0]   toe_q, tow_q;
  err_e              err_q;

  // Named internal events for the assertions.
  logic [2:0]        last_s, last_m1;
  logic              in_cmd, is_last, ev_prog_cmd, ev_data_wr, ev_read_array, ev_poll_rd1;
  logic              unsupported, tmr_tick, pe_fire, pe_complete;
  err_e              pe_code;
  logic [LEN_W:0]    step_bytes, adv_idx;
  logic [ADDR_W-1:0] base_a, word_a;
  op_t               cur_op;

  assign last_s        = last_step(unl_q, prog_q);
  assign last_m1       = last_s - 3'd1;
  assign in_cmd        = (st_q == S_CMD);
  assign is_last       = (step_q == last_s);
  assign ev_prog_cmd   = in_cmd && prog_q && (step_q == last_m1);
  assign ev_data_wr    = in_cmd && prog_q && is_last;
  assign ev_read_array = (st_q == S_RA);
  assign ev_poll_rd1   = (st_q == S_RD1);
  assign unsupported   = dialect_i[1] || (wsel_i == 2'd3);

  assign step_bytes = (LEN_W + 1)'(1) << wsel_q;
  assign adv_idx    = prog_q ? (idx_q + step_bytes) : '0;
  assign base_a     = align(ofs_q, wsel_q);
  assign word_a     = align(ofs_q + ADDR_W'(idx_q), wsel_q);
  assign cur_op     = op_for_step(unl_q, prog_q, step_q, ofs_q, word_a, dat_q);

  fseq_tick_timer #(.CYC_PER_TICK(CYC_PER_TICK)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == S_PCHK),
    .en_i   (st_q == S_TICK),
    .tick_o (tmr_tick)
  );

  fseq_poll_eval #(.DW(DW)) u_eval (
    .unl_i      (unl_q),
    .st_a_i     (st0_q),
    .st_b_i     (bus_rdata_i),
    .complete_o (pe_complete),
    .code_o     (pe_code)
  );

  assign pe_fire = ((st_q == S_RD2) && !unl_q) || (st_q == S_RD3);

  assign bus_wr_o    = in_cmd || ev_read_array;
  assign bus_rd_o    = ev_poll_rd1 || ((st_q == S_RD2) && unl_q);
  assign bus_addr_o  = ev_read_array ? '0 : (in_cmd ? align(cur_op.addr, wsel_q) : base_a);
  assign bus_wdata_o = ev_read_array ? DW'(C_READ_ARRAY) : cur_op.data;
  assign buf_re_o    = (st_q == S_FETCH);
  assign buf_addr_o  = idx_q[LEN_W-1:0];
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; step_q <= '0; prog_q <= 1'b0; unl_q <= 1'b0;
      busy_q <= 1'b0; done_q <= 1'b0; idx_q <= '0; len_q <= '0;
      dat_q <= '0; st0_q <= '0; rem_q <= '0; ofs_q <= '0; wsel_q <= '0;
      toe_q <= '0; tow_q <= '0; err_q <= E_NONE;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          if (unsupported) begin
            err_q  <= E_NODEV;
            done_q <= 1'b1;
          end else begin
            err_q  <= E_NONE;
            busy_q <= 1'b1;
            ofs_q  <= blk_ofs_i;
            len_q  <= buf_len_i;
            unl_q  <= dialect_i[0];
            wsel_q <= wsel_i;
            toe_q  <= erase_to_i;
            tow_q  <= write_to_i;
            step_q <= '0;
            prog_q <= 1'b0;
            idx_q  <= '0;
            st_q   <= S_CMD;
          end
        end
        S_CMD: begin
          if (is_last) begin
            rem_q  <= poll_limit(prog_q ? tow_q : toe_q);
            step_q <= '0;
            st_q   <= S_PCHK;
          end else begin
            step_q <= step_q + 3'd1;
          end
        end
        S_PCHK: begin
          if (rem_q == '0) begin
            err_q <= E_TIMEOUT;
            st_q  <= S_RA;
          end else begin
            st_q <= S_TICK;
          end
        end
        S_TICK: if (tmr_tick) begin
          rem_q <= rem_q - RW'(1);
          st_q  <= S_RD1;
        end
        S_RD1: st_q <= S_RD2;
        S_RD2: begin
          st0_q <= bus_rdata_i;
          if (unl_q) st_q <= S_RD3;
        end
        S_FETCH:   st_q <= S_FETCH_W;
        S_FETCH_W: begin
          dat_q  <= buf_rdata_i & lane_mask(wsel_q);
          step_q <= '0;
          st_q   <= S_CMD;
        end
        S_RA: begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
      if (pe_fire) begin
        if (!pe_complete) begin
          st_q <= S_PCHK;
        end else if (pe_code != E_NONE) begin
          err_q <= pe_code;
          st_q  <= S_RA;
        end else if (adv_idx < {1'b0, len_q}) begin
          idx_q  <= adv_idx;
          prog_q <= 1'b1;
          st_q   <= S_FETCH;
        end else begin
          st_q <= S_RA;
        end
      end
    end
  end

  AST_DATA_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_prog_cmd |=> ev_data_wr);                                   // R4
  AST_POLL_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_poll_rd1 |-> $past(tmr_tick));                              // R8
  AST_READ_ARRAY_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (err_o != 3'(E_NODEV))) |-> $past(ev_read_array));  // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(bus_wr_o || bus_rd_o || buf_re_o));              // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                           // R11
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(ofs_q) && $stable(unl_q) && $stable(len_q))); // R11
endmodule

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
  localparam int ADDR_W = 16;
  localparam int DW     = 32;
  localparam int LEN_W  = 8;
  localparam int TO_W   = 4;
  localparam int CYC    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              start = 1'b0;
  logic [ADDR_W-1:0] ofs = '0;
  logic [LEN_W-1:0]  len = '0;
  logic [1:0]        dial = '0, ws = '0;
  logic [TO_W-1:0]   toe = '0, tow = '0;
  logic              buf_re, bus_wr, bus_rd, busy, done;
  logic [LEN_W-1:0]  buf_addr;
  logic [DW-1:0]     buf_q = '0, rdata = '0, wdata;
  logic [ADDR_W-1:0] addr;
  logic [2:0]        err;

  flash_seq #(.ADDR_W(ADDR_W), .DW(DW), .LEN_W(LEN_W), .TO_W(TO_W), .CYC_PER_TICK(CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_ofs_i(ofs), .buf_len_i(len),
    .dialect_i(dial), .wsel_i(ws), .erase_to_i(toe), .write_to_i(tow),
    .buf_re_o(buf_re), .buf_addr_o(buf_addr), .buf_rdata_i(buf_q),
    .bus_wr_o(bus_wr), .bus_rd_o(bus_rd), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_rdata_i(rdata), .busy_o(busy), .done_o(done), .err_o(err));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Flash and buffer models
  logic [7:0] mem [256];
  bit   m_unl = 0, last_rd = 0;
  int   reads = 0, op_idx = 0, m_ra = 0, m_bad = -1;
  logic [31:0] m_bad_st = '0;

  function automatic logic [31:0] flash_val();
    if (m_unl) return (reads < 2 * m_ra) ? (reads[0] ? 32'h40 : 32'h0) : 32'h5A;
    if (reads < m_ra) return 32'h0000_007F;
    return (op_idx == m_bad) ? m_bad_st : 32'hFFFF_FF81;
  endfunction

  always @(posedge clk) begin
    if (bus_wr) begin
      if (last_rd) op_idx++;
      reads = 0; last_rd = 0;
    end
    if (bus_rd) begin
      rdata <= flash_val();
      reads++; last_rd = 1;
    end
    if (buf_re)
      buf_q <= {mem[8'(buf_addr + 3)], mem[8'(buf_addr + 2)], mem[8'(buf_addr + 1)], mem[buf_addr]};
  end

  // Scoreboard
  typedef struct {
    bit wr; logic [31:0] a; logic [31:0] d; bit b2b; bit tick; int req;
  } txn_t;
  txn_t q[$];
  int cyc = 0, last_cyc = -100;

  function automatic void push(bit wr, logic [31:0] a, logic [31:0] d, bit b2b, bit tick, int req);
    txn_t t;
    t.wr = wr; t.a = a & 32'hFFFF; t.d = d; t.b2b = b2b; t.tick = tick; t.req = req;
    q.push_back(t);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (bus_wr || bus_rd) begin
        if (q.size() == 0) begin
          chk(0, "R10", "unexpected bus transaction at address", int'(addr), 0);
        end else begin
          txn_t t;
          string rq;
          t = q.pop_front();
          rq = $sformatf("R%0d", t.req);
          chk(bus_wr == t.wr, rq, "transaction kind (1=write)", int'(bus_wr), int'(t.wr));
          chk(32'(addr) == t.a, rq, "address", int'(addr), int'(t.a));
          if (t.wr) chk(wdata == t.d, rq, "write data", int'(wdata), int'(t.d));
          if (t.b2b) chk(cyc == last_cyc + 1, "R4", "cycles since previous transaction", cyc - last_cyc, 1);
          if (t.tick) chk(cyc - last_cyc > CYC, "R8", "gap before poll (>tick)", cyc - last_cyc, CYC + 1);
        end
        last_cyc = cyc;
      end
    end
  end

  function automatic logic [31:0] al(int a, logic [1:0] w);
    return 32'(a) & ~((32'd1 << w) - 1);
  endfunction

  function automatic int decode(logic [31:0] s);
    if (s[1]) return 1;
    if (s[4]) return 2;
    if (s[5]) return 3;
    if ((s & 32'h4C) != 0) return 4;
    return 0;
  endfunction

  // Pushes the polls of one operation and returns its result code.
  function automatic int polls(bit u, int o, logic [1:0] w, int ra, int to, int opn, int bad,
                               logic [31:0] bst, int req);
    int lim = to * 10;
    int n = ra + 1;
    bit tmo = n > lim;
    if (tmo) n = lim;
    for (int k = 0; k < n; k++) begin
      push(0, al(o, w), 0, 0, 1, req);
      if (u) push(0, al(o, w), 0, 1, 0, 7);
    end
    if (tmo) return 5;
    if (!u && opn == bad) return decode(bst);
    return 0;
  endfunction

  task automatic run_case(input string name, input bit u, input logic [1:0] w, input int o,
                          input int ln, input int e_to, input int w_to, input int ra,
                          input int bad, input logic [31:0] bst, input bit poke, input int ereq);
    int exp_err, bytes, opn;
    bytes = 1 << w;
    if (u) begin
      push(1, al(o + 'h555, w), 8'hAA, 0, 0, 3);
      push(1, al(o + 'h2AA, w), 8'h55, 1, 0, 3);
      push(1, al(o + 'h555, w), 8'h80, 1, 0, 3);
      push(1, al(o + 'h555, w), 8'hAA, 1, 0, 3);
      push(1, al(o + 'h2AA, w), 8'h55, 1, 0, 3);
      push(1, al(o, w),         8'h30, 1, 0, 3);
    end else begin
      push(1, al(o, w), 8'h20, 0, 0, 2);
      push(1, al(o, w), 8'hD0, 1, 0, 2);
    end
    exp_err = polls(u, o, w, ra, e_to, 0, bad, bst, u ? 7 : 5);
    opn = 1;
    if (exp_err == 0) begin
      for (int i = 0; i < ln; i += bytes) begin
        logic [31:0] word, mk;
        mk = (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        word = {mem[8'(i + 3)], mem[8'(i + 2)], mem[8'(i + 1)], mem[8'(i)]} & mk;
        if (u) begin
          push(1, al('h555, w), 8'hAA, 0, 0, 4);
          push(1, al('h2AA, w), 8'h55, 1, 0, 4);
          push(1, al('h555, w), 8'hA0, 1, 0, 4);
        end else begin
          push(1, al(o + i, w), 8'h40, 0, 0, 4);
        end
        push(1, al(o + i, w), word, 1, 0, 4);
        exp_err = polls(u, o, w, ra, w_to, opn, bad, bst, u ? 7 : 5);
        opn++;
        if (exp_err != 0) break;
      end
    end
    push(1, 0, 8'hFF, 0, 0, 9);

    m_unl = u; m_ra = ra; m_bad = bad; m_bad_st = bst;
    reads = 0; op_idx = 0; last_rd = 0;
    dial = {1'b0, u}; ws = w; ofs = ADDR_W'(o); len = LEN_W'(ln);
    toe = TO_W'(e_to); tow = TO_W'(w_to);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R11", {name, " busy after start"}, int'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; dial = 2'd0; ofs = 16'h7777; len = 8'd1; ws = 2'd0;
      @(negedge clk) start = 1'b0;
    end
    begin
      int n = 0;
      while (!done && n < 20000) begin @(negedge clk); n++; end
      chk(n < 20000, "R11", {name, " run completes"}, n, 0);
    end
    chk(int'(err) == exp_err, $sformatf("R%0d", ereq), {name, " result code"}, int'(err), exp_err);
    chk(busy == 1'b0, "R11", {name, " busy cleared at done"}, int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", {name, " done is one cycle"}, int'(done), 0);
    repeat (3) @(negedge clk);
    chk(int'(err) == exp_err, "R11", {name, " code held"}, int'(err), exp_err);
    chk(q.size() == 0, "R9", {name, " all expected transactions seen"}, q.size(), 0);
    q.delete();
  endtask

  task automatic run_bad(input string name, input logic [1:0] d, input logic [1:0] w);
    dial = d; ws = w; ofs = 16'h0100; len = 8'd4; toe = 4'd1; tow = 4'd1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(done == 1'b1, "R10", {name, " done next cycle"}, int'(done), 1);
    chk(int'(err) == 6, "R10", {name, " no-device code"}, int'(err), 6);
    chk(busy == 1'b0, "R10", {name, " never busy"}, int'(busy), 0);
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R10", {name, " single done"}, int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "busy/done in reset", int'({busy, done}), 0);
    chk(err == 0, "R1", "error code in reset", int'(err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bus_wr && !bus_rd && !buf_re, "R1", "no activity after reset", int'({bus_wr, bus_rd, buf_re}), 0);

    run_case("sr w2",        0, 2'd1, 'h1234, 6, 1, 1, 2, -1, 0, 0, 5);   // R2 R4 R5
    run_case("sr w4 unalign",0, 2'd2, 'h3003, 9, 1, 1, 0, -1, 0, 0, 12);  // R12
    run_case("ul w1",        1, 2'd0, 'h0800, 3, 1, 1, 3, -1, 0, 0, 7);   // R3 R7
    run_case("ul w2 unalign",1, 2'd1, 'h0a01, 4, 2, 2, 1, -1, 0, 0, 12);  // R12
    run_case("erase protect",0, 2'd1, 'h2000, 8, 1, 1, 1, 0, 32'h0000_00B2, 0, 9); // R6 R9
    run_case("prog error",   0, 2'd1, 'h2000, 8, 1, 1, 0, 2, 32'h0000_00B0, 0, 6); // R6
    run_case("erase error",  0, 2'd0, 'h0040, 2, 1, 1, 0, 0, 32'h0000_00E0, 0, 6); // R6
    run_case("other error",  0, 2'd0, 'h0040, 2, 1, 1, 0, 1, 32'hFFFF_FF89, 0, 6); // R6
    run_case("erase timeout",0, 2'd1, 'h0400, 4, 1, 3, 15, -1, 0, 0, 8);  // R8
    run_case("zero timeout", 0, 2'd1, 'h0400, 4, 0, 3, 0, -1, 0, 0, 8);   // R8
    run_case("ul prog tmo",  1, 2'd1, 'h0600, 4, 2, 1, 12, -1, 0, 0, 8);  // R8 R7
    run_case("start busy",   0, 2'd1, 'h1100, 4, 1, 1, 1, -1, 0, 1, 11);  // R11
    run_case("empty buffer", 1, 2'd2, 'h1000, 0, 1, 1, 0, -1, 0, 0, 9);   // R9
    run_bad("dialect 2", 2'd2, 2'd0);                                     // R10
    run_bad("dialect 3", 2'd3, 2'd1);                                     // R10
    run_bad("width 3",   2'd0, 2'd3);                                     // R10

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule